// File: doc/BRIEF.md
# Configuration-Space Access Decoder

This block sits behind a register-style access port and serves a small emulated nonvolatile configuration store. Each access carries a region-select bit and a 16-bit address; when the select bit is set and address bit 15 is high, the address is decoded into one of four windows. These are user-identification words, the fixed device and revision identifiers, the configuration words, and a read-only device-information and calibration area.

Each window has its own read and write permission. A read strobe loads the 16-bit read data pair (high and low bytes) one clock later. A read that falls in no window clears the pair to zero, so stale data is never returned. A commit-write strobe stores the write byte pair into a writable word. A write that targets a read-only or unmapped location changes nothing and raises a single-cycle error pulse.

Writable words come out of reset with computed values. The read-only areas return fixed or computed constants, so their contents are predictable.

Top module: `cfgspace_access`

## Requirements
- R1: After reset the read data pair is 0x0000 and `wrError` is low. User word i resets to 0xFF00+i and configuration word i resets to 0x3FF0+i.
- R2: The read data pair changes only on a read strobe. The new value is visible in the cycle after the strobe, and it holds through idle cycles and through writes.
- R3: Addresses 0x8000 to 0x8003 map to user words 0 to 3. These words can be read and written.
- R4: Address 0x8005 reads the device ID 0x30A5 and address 0x8006 reads the revision ID 0x2003. A write to either address is refused.
- R5: Addresses 0x8007 to 0x800B map to configuration words 0 to 4. These words can be read and written.
- R6: Address 0x8100+k, for k from 0 to 511, reads ((k*0x9E37) mod 2^16) XOR 0x5A5A. A write to this area is refused.
- R7: A read with the select bit high, at an address outside every window, clears the data pair to 0x0000. This includes 0x8004, 0x800C to 0x80FF, 0x8300 and above, and any address with bit 15 clear.
- R8: While the select bit is low, every read clears the data pair to 0x0000 and every write is refused.
- R9: A refused write leaves every stored word unchanged. It drives `wrError` high for exactly the one cycle after the write strobe.
- R10: An accepted write stores {wrHi, wrLo} and keeps `wrError` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regionSel | input | 1 | Selects configuration space when 1 |
| addr | input | 16 | Word address |
| wrLo | input | 8 | Write data, low byte |
| wrHi | input | 8 | Write data, high byte |
| rdStrobe | input | 1 | Read request, one cycle |
| wrStrobe | input | 1 | Commit-write request, one cycle |
| rdLo | output | 8 | Read data register, low byte |
| rdHi | output | 8 | Read data register, high byte |
| wrError | output | 1 | One-cycle pulse after a refused write |

## Verification
The hardest case to reach from the ports is a refused write whose effect cannot be seen directly. Read-only words never move, so a wrongly accepted write shows up only as corruption of a neighbouring writable word, or of the data pair. The stimulus therefore mixes refused writes, aimed at the read-only windows, the gap word, the window edges and the deselected region, with writes to the user and configuration words. It then sweeps every writable word and compares it against a shadow copy in the bench. Window edges (0x8003/0x8004/0x8005, 0x800B/0x800C, 0x80FF/0x8100, 0x82FF/0x8300) are hit directly. Random addresses are drawn with a bias toward the windows.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_USER,
    WIN_DEVID,
    WIN_REVID,
    WIN_CFG,
    WIN_INFO
  } winKind_t;

  typedef struct packed {
    logic              rdLoad;   // read hits a window
    logic              rdClear;  // read misses every window
    logic              wrUser;   // accepted write to a user word
    logic              wrCfg;    // accepted write to a configuration word
    winKind_t          win;
    logic [ADDR_W-1:0] idx;      // offset inside the window
  } ctlStrobes_t;

endpackage

// File: rtl/cfgspace_ctrl.sv
module cfgspace_ctrl
  import cfgspace_pkg::*;
#(
  parameter logic [ADDR_W-1:0] USER_BASE = 16'h8000,
  parameter int                USER_CNT  = 4,
  parameter logic [ADDR_W-1:0] DEVID_ADR = 16'h8005,
  parameter logic [ADDR_W-1:0] REVID_ADR = 16'h8006,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 16'h8007,
  parameter int                CFG_CNT   = 5,
  parameter logic [ADDR_W-1:0] INFO_BASE = 16'h8100,
  parameter int                INFO_CNT  = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regionSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  output ctlStrobes_t       ctl,
  output logic              wrError
);

  localparam logic [ADDR_W:0] USER_END = {1'b0, USER_BASE} + (ADDR_W+1)'(USER_CNT);
  localparam logic [ADDR_W:0] CFG_END  = {1'b0, CFG_BASE}  + (ADDR_W+1)'(CFG_CNT);
  localparam logic [ADDR_W:0] INFO_END = {1'b0, INFO_BASE} + (ADDR_W+1)'(INFO_CNT);

  logic [ADDR_W:0] addrExt;
  winKind_t        win;
  logic [ADDR_W-1:0] idx;
  logic            refused;

  assign addrExt = {1'b0, addr};

  always_comb begin
    win = WIN_NONE;
    idx = '0;
    if (regionSel && addr[ADDR_W-1]) begin
      if (addrExt >= {1'b0, USER_BASE} && addrExt < USER_END) begin
        win = WIN_USER;
        idx = addr - USER_BASE;
      end else if (addr == DEVID_ADR) begin
        win = WIN_DEVID;
      end else if (addr == REVID_ADR) begin
        win = WIN_REVID;
      end else if (addrExt >= {1'b0, CFG_BASE} && addrExt < CFG_END) begin
        win = WIN_CFG;
        idx = addr - CFG_BASE;
      end else if (addrExt >= {1'b0, INFO_BASE} && addrExt < INFO_END) begin
        win = WIN_INFO;
        idx = addr - INFO_BASE;
      end
    end
  end

  always_comb begin
    ctl.win     = win;
    ctl.idx     = idx;
    ctl.rdLoad  = rdStrobe && (win != WIN_NONE);
    ctl.rdClear = rdStrobe && (win == WIN_NONE);
    ctl.wrUser  = wrStrobe && (win == WIN_USER);
    ctl.wrCfg   = wrStrobe && (win == WIN_CFG);
  end

  assign refused = wrStrobe && !(ctl.wrUser || ctl.wrCfg);

  always_ff @(posedge clk) begin
    if (!rstN) wrError <= 1'b0;
    else       wrError <= refused;
  end

  // R9: an error pulse is always caused by a write strobe one cycle earlier
  assert_err_after_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrError |-> $past(wrStrobe));

  // R4/R6: writes into read-only windows are always flagged
  assert_ro_write_flagged_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && (win == WIN_DEVID || win == WIN_REVID || win == WIN_INFO)) |=> wrError);

  // R8: deselected region never yields an accepted write
  assert_desel_refused_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !regionSel) |=> wrError);

endmodule

// File: rtl/cfgspace_data.sv
module cfgspace_data
  import cfgspace_pkg::*;
#(
  parameter int                USER_CNT      = 4,
  parameter int                CFG_CNT       = 5,
  parameter logic [DATA_W-1:0] USER_RST_BASE = 16'hFF00,
  parameter logic [DATA_W-1:0] CFG_RST_BASE  = 16'h3FF0,
  parameter logic [DATA_W-1:0] DEV_ID        = 16'h30A5,
  parameter logic [DATA_W-1:0] REV_ID        = 16'h2003,
  parameter logic [DATA_W-1:0] INFO_MULT     = 16'h9E37,
  parameter logic [DATA_W-1:0] INFO_MASK     = 16'h5A5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] wrWord,
  output logic [DATA_W-1:0] rdWord
);

  logic [DATA_W-1:0] userMem [USER_CNT];
  logic [DATA_W-1:0] cfgMem  [CFG_CNT];
  logic [USER_CNT*DATA_W-1:0] userFlat;
  logic [CFG_CNT*DATA_W-1:0]  cfgFlat;
  logic [DATA_W-1:0] infoWord;
  logic [2*DATA_W-1:0] infoProd;
  logic [DATA_W-1:0] rdNext;

  for (genvar g = 0; g < USER_CNT; g++) begin : gUser
    always_ff @(posedge clk) begin
      if (!rstN)
        userMem[g] <= USER_RST_BASE + DATA_W'(g);
      else if (ctl.wrUser && ctl.idx == ADDR_W'(g))
        userMem[g] <= wrWord;
    end
    assign userFlat[g*DATA_W +: DATA_W] = userMem[g];
  end

  for (genvar g = 0; g < CFG_CNT; g++) begin : gCfg
    always_ff @(posedge clk) begin
      if (!rstN)
        cfgMem[g] <= CFG_RST_BASE + DATA_W'(g);
      else if (ctl.wrCfg && ctl.idx == ADDR_W'(g))
        cfgMem[g] <= wrWord;
    end
    assign cfgFlat[g*DATA_W +: DATA_W] = cfgMem[g];
  end

  assign infoProd = {{DATA_W{1'b0}}, ctl.idx} * {{DATA_W{1'b0}}, INFO_MULT};
  assign infoWord = infoProd[DATA_W-1:0] ^ INFO_MASK;

  always_comb begin
    rdNext = '0;
    unique case (ctl.win)
      WIN_USER: begin
        for (int i = 0; i < USER_CNT; i++)
          if (ctl.idx == ADDR_W'(i)) rdNext = userMem[i];
      end
      WIN_CFG: begin
        for (int i = 0; i < CFG_CNT; i++)
          if (ctl.idx == ADDR_W'(i)) rdNext = cfgMem[i];
      end
      WIN_DEVID: rdNext = DEV_ID;
      WIN_REVID: rdNext = REV_ID;
      WIN_INFO:  rdNext = infoWord;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdWord <= '0;
    else if (ctl.rdClear)   rdWord <= '0;
    else if (ctl.rdLoad)    rdWord <= rdNext;
  end

  // R7: a missed read leaves zeros in the data pair
  assert_miss_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdClear |=> (rdWord == '0));

  // R2: without a read the data pair holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.rdLoad || ctl.rdClear) |=> $stable(rdWord));

  // R4: device ID read returns the fixed identifier
  assert_devid_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdLoad && ctl.win == WIN_DEVID) |=> (rdWord == DEV_ID));

  // R9: storage moves only on an accepted write
  assert_store_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.wrUser || ctl.wrCfg) |=> ($stable(userFlat) && $stable(cfgFlat)));

endmodule

// File: rtl/cfgspace_access.sv
module cfgspace_access
  import cfgspace_pkg::*;
#(
  parameter int USER_CNT = 4,
  parameter int CFG_CNT  = 5,
  parameter int INFO_CNT = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regionSel,
  input  logic [15:0] addr,
  input  logic [7:0]  wrLo,
  input  logic [7:0]  wrHi,
  input  logic        rdStrobe,
  input  logic        wrStrobe,
  output logic [7:0]  rdLo,
  output logic [7:0]  rdHi,
  output logic        wrError
);

  ctlStrobes_t       ctl;
  logic [DATA_W-1:0] rdWord;

  cfgspace_ctrl #(
    .USER_CNT (USER_CNT),
    .CFG_CNT  (CFG_CNT),
    .INFO_CNT (INFO_CNT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regionSel (regionSel),
    .addr      (addr),
    .rdStrobe  (rdStrobe),
    .wrStrobe  (wrStrobe),
    .ctl       (ctl),
    .wrError   (wrError)
  );

  cfgspace_data #(
    .USER_CNT (USER_CNT),
    .CFG_CNT  (CFG_CNT)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .wrWord ({wrHi, wrLo}),
    .rdWord (rdWord)
  );

  assign rdLo = rdWord[7:0];
  assign rdHi = rdWord[15:8];

endmodule

// File: tb/cfgspace_access_tb.sv
module cfgspace_access_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regionSel = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wrLo = '0, wrHi = '0;
  logic        rdStrobe = 1'b0, wrStrobe = 1'b0;
  logic [7:0]  rdLo, rdHi;
  logic        wrError;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] userShadow [4];
  logic [15:0] cfgShadow  [5];
  logic [15:0] lastRead = '0;

  always #5 clk = ~clk;

  cfgspace_access u_dut (
    .clk(clk), .rstN(rstN), .regionSel(regionSel), .addr(addr),
    .wrLo(wrLo), .wrHi(wrHi), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .rdLo(rdLo), .rdHi(rdHi), .wrError(wrError)
  );

  function automatic logic [15:0] infoVal(input int k);
    logic [31:0] p;
    p = k * 32'h9E37;
    return p[15:0] ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] expRead(input logic sel, input logic [15:0] a);
    if (!sel) return 16'h0000;
    if (a >= 16'h8000 && a <= 16'h8003) return userShadow[a - 16'h8000];
    if (a == 16'h8005) return 16'h30A5;
    if (a == 16'h8006) return 16'h2003;
    if (a >= 16'h8007 && a <= 16'h800B) return cfgShadow[a - 16'h8007];
    if (a >= 16'h8100 && a <= 16'h82FF) return infoVal(int'(a - 16'h8100));
    return 16'h0000;
  endfunction

  function automatic bit writable(input logic sel, input logic [15:0] a);
    return sel && ((a >= 16'h8000 && a <= 16'h8003) || (a >= 16'h8007 && a <= 16'h800B));
  endfunction

  function automatic string reqOf(input logic sel, input logic [15:0] a);
    if (!sel) return "R8";
    if (a >= 16'h8000 && a <= 16'h8003) return "R3";
    if (a == 16'h8005 || a == 16'h8006) return "R4";
    if (a >= 16'h8007 && a <= 16'h800B) return "R5";
    if (a >= 16'h8100 && a <= 16'h82FF) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic sel, input logic [15:0] a);
    logic [15:0] e;
    e = expRead(sel, a);
    @(negedge clk);
    regionSel = sel; addr = a; rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    check(reqOf(sel, a), {16'h0, rdHi, rdLo}, {16'h0, e});
    lastRead = e;
  endtask

  task automatic doWrite(input logic sel, input logic [15:0] a, input logic [15:0] d);
    bit ok;
    ok = writable(sel, a);
    @(negedge clk);
    regionSel = sel; addr = a; wrHi = d[15:8]; wrLo = d[7:0]; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
    if (ok) begin
      if (a <= 16'h8003) userShadow[a - 16'h8000] = d;
      else               cfgShadow[a - 16'h8007] = d;
      check("R10", {31'h0, wrError}, 32'h0);
    end else begin
      check("R9", {31'h0, wrError}, 32'h1);
    end
    @(negedge clk);
    check("R9", {31'h0, wrError}, 32'h0);
    // R2: a write leaves the data pair alone
    check("R2", {16'h0, rdHi, rdLo}, {16'h0, lastRead});
  endtask

  task automatic sweepWritable();
    for (int i = 0; i < 4; i++) doRead(1'b1, 16'h8000 + 16'(i));
    for (int i = 0; i < 5; i++) doRead(1'b1, 16'h8007 + 16'(i));
  endtask

  function automatic logic [15:0] pickAddr();
    case ($urandom_range(0, 6))
      0: return 16'h8000 + 16'($urandom_range(0, 3));
      1: return 16'h8004 + 16'($urandom_range(0, 2));
      2: return 16'h8007 + 16'($urandom_range(0, 5));
      3: return 16'h8100 + 16'($urandom_range(0, 511));
      4: return 16'h80FF + 16'($urandom_range(0, 1)) * 16'h0201;
      5: return 16'($urandom());
      default: return 16'h8000 + 16'($urandom_range(0, 16'h03FF));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 4; i++) userShadow[i] = 16'hFF00 + 16'(i);
    for (int i = 0; i < 5; i++) cfgShadow[i]  = 16'h3FF0 + 16'(i);

    repeat (3) @(negedge clk);
    check("R1", {16'h0, rdHi, rdLo}, 32'h0);
    check("R1", {31'h0, wrError}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset contents
    sweepWritable();

    // R4, R6 read-only values and info edges
    doRead(1'b1, 16'h8005);
    doRead(1'b1, 16'h8006);
    doRead(1'b1, 16'h8100);
    doRead(1'b1, 16'h82FF);
    // R7 gaps and edges
    doRead(1'b1, 16'h8004);
    doRead(1'b1, 16'h800C);
    doRead(1'b1, 16'h80FF);
    doRead(1'b1, 16'h8300);
    doRead(1'b1, 16'h0003);
    // R8 deselected
    doRead(1'b0, 16'h8005);

    // R2 hold through idle cycles after a nonzero read
    doRead(1'b1, 16'h8006);
    repeat (5) @(negedge clk);
    check("R2", {16'h0, rdHi, rdLo}, 32'h2003);

    // R3, R5, R10 accepted writes at window edges
    doWrite(1'b1, 16'h8000, 16'h1234);
    doWrite(1'b1, 16'h8003, 16'hABCD);
    doWrite(1'b1, 16'h8007, 16'h0F0F);
    doWrite(1'b1, 16'h800B, 16'hC3C3);
    // R9 refused writes
    doWrite(1'b1, 16'h8004, 16'hDEAD);
    doWrite(1'b1, 16'h8005, 16'hDEAD);
    doWrite(1'b1, 16'h8006, 16'hDEAD);
    doWrite(1'b1, 16'h800C, 16'hDEAD);
    doWrite(1'b1, 16'h8100, 16'hDEAD);
    doWrite(1'b0, 16'h8001, 16'hDEAD);
    doWrite(1'b1, 16'h0000, 16'hDEAD);
    sweepWritable();
    doRead(1'b1, 16'h8005);
    doRead(1'b1, 16'h8100);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic sel;
      logic [15:0] a;
      sel = ($urandom_range(0, 9) != 0);
      a = pickAddr();
      if ($urandom_range(0, 1) == 0) doRead(sel, a);
      else doWrite(sel, a, 16'($urandom()));
      if (n % 100 == 99) sweepWritable();
    end
    sweepWritable();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule